// File: doc/BRIEF.md
# Multiprocessor Interrupt Register Block

This block is the memory-mapped register front end of a chipset that serves up to four processors. It holds one 64-bit interrupt mask register and one 64-bit interrupt request register for each processor. It also holds a shared raw device interrupt register and a miscellaneous register whose bit 7 records a pending real-time-clock interrupt. Software reaches the block through a single-cycle request port. The block forms a register index by ANDing the physical address with a mask parameter and shifting the result right by six, so each register occupies a 64-byte slot.

Only full 64-bit accesses are accepted. Every access that the block does not support is answered with an error flag rather than dropped silently. This covers narrow sizes, writes to read-only registers, register indices for features that are not built, and unmapped indices. A pulse from the real-time clock raises the RTC interrupt line toward processor 0. The line stays high until software writes the miscellaneous register with bit 7 set.

Top module: `irq_regblk`

## Requirements
- R1: After reset, `rsp_ready` and `rtc_irq` are 0, and every readable register (mask, request, raw, miscellaneous, control/status) reads 0.
- R2: Every cycle with `req_valid` high produces exactly one cycle of `rsp_ready` in the next cycle. `rsp_ready` is low in any cycle that does not follow a request.
- R3: `req_size` encodes log2 of the byte count (0=1 B, 1=2 B, 2=4 B, 3=8 B). Any value other than 3 gives `rsp_err`=1, `rsp_rdata`=0, and no register change.
- R4: Indices 8+n (n = 0..NUM_CPU-1) are the mask registers of processor n. Each keeps the full 64-bit value last written to it, reads it back, and is independent of the others.
- R5: Indices 12+n (request register of processor n) and index 16 (raw device interrupt register) read 0 after reset. A write to any of them gives `rsp_err`=1 and changes nothing.
- R6: Index 0 (control/status) reads 0 without error. A write to it gives `rsp_err`=1 and changes nothing.
- R7: A one-cycle `rtc_pulse` sets bit 7 of the miscellaneous register (index 2, reads 64'h80) and drives `rtc_irq` high from the next cycle on. `rtc_irq` stays high until the interrupt is acknowledged.
- R8: A 64-bit write to index 2 with data bit 7 set clears bit 7 and drops `rtc_irq` in the cycle the response appears. A write there with bit 7 clear gives `rsp_err`=1 and changes nothing.
- R9: Indices 1, 4..7, 17, 20..27 (features that are not built) and every other unmapped index give `rsp_err`=1 on both read and write, with `rsp_rdata`=0 and no register change.
- R10: Only the address bits selected by `ADDR_MASK` (default bits 10..6) take part in the decode. Bits 5..0 and bits outside the mask have no effect on which register is reached.
- R11: When an RTC pulse and an acknowledge write land in the same cycle, the pulse wins and `rtc_irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Physical address |
| req_size | input | 2 | log2 of access size in bytes |
| req_wdata | input | 64 | Write data |
| rtc_pulse | input | 1 | Real-time-clock event pulse |
| rsp_ready | output | 1 | Response strobe, cycle after the request |
| rsp_err | output | 1 | Access error, valid with rsp_ready |
| rsp_rdata | output | 64 | Read data, valid with rsp_ready |
| rtc_irq | output | 1 | RTC interrupt line toward processor 0 |

## Verification
The bench checks that mask writes actually persist. After each write it reads every processor's mask back, because a block that aliased the processor select would corrupt a neighbour's mask. Each rejected write is followed by a read of the register it targeted. This catches a design that flags an error but still commits the data, such as a narrow write landing in a mask or a bit-7-clear write wiping the RTC flag. The bench also drives an RTC pulse and an acknowledge in the same cycle; giving the acknowledge priority there would lose an interrupt. Decoding is tested with stray low and high address bits, which a design that ignored the mask parameter would route to an unmapped index.

// File: rtl/irq_regblk_pkg.sv
package irq_regblk_pkg;

    localparam int DATA_W     = 64;
    localparam int SLOT_SHIFT = 6;
    localparam int RTC_BIT    = 7;
    localparam logic [1:0] SIZE_DWORD = 2'd3;

    // register index map (index = (addr & mask) >> 6)
    localparam int IDX_CTRL      = 0;
    localparam int IDX_TIMING    = 1;   // not built
    localparam int IDX_MISC      = 2;
    localparam int IDX_ARRAY_LO  = 4;   // 4..7 not built
    localparam int IDX_MASK_BASE = 8;
    localparam int IDX_REQ_BASE  = 12;
    localparam int IDX_RAW       = 16;
    localparam int IDX_PROBE     = 17;  // not built
    localparam int IDX_COUNT_LO  = 20;  // 20..23 not built
    localparam int IDX_MSG_LO    = 24;  // 24..27 not built
    localparam int SLOTS_PER_BANK = 4;

    typedef enum logic [2:0] {
        KIND_CTRL,
        KIND_MISC,
        KIND_MASK,
        KIND_REQ,
        KIND_RAW,
        KIND_BAD
    } reg_kind_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_regblk_pkg::*;
#(
    parameter int               ADDR_W    = 36,
    parameter logic [ADDR_W-1:0] ADDR_MASK = 36'h0_0000_07C0,
    parameter int               NUM_CPU   = 4,
    localparam int              CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output reg_kind_e         kind,
    output logic [CPU_W-1:0]  cpu_sel,
    output logic              size_ok
);

    logic [ADDR_W-1:0] slot;
    logic [ADDR_W-1:0] mask_off;
    logic [ADDR_W-1:0] req_off;

    always_comb begin
        slot     = (addr & ADDR_MASK) >> SLOT_SHIFT;
        mask_off = slot - ADDR_W'(IDX_MASK_BASE);
        req_off  = slot - ADDR_W'(IDX_REQ_BASE);
        size_ok  = (size == SIZE_DWORD);
        kind     = KIND_BAD;
        cpu_sel  = '0;

        if (slot == ADDR_W'(IDX_CTRL)) begin
            kind = KIND_CTRL;
        end else if (slot == ADDR_W'(IDX_MISC)) begin
            kind = KIND_MISC;
        end else if (slot >= ADDR_W'(IDX_MASK_BASE) &&
                     slot <  ADDR_W'(IDX_MASK_BASE + NUM_CPU)) begin
            kind    = KIND_MASK;
            cpu_sel = CPU_W'(mask_off);
        end else if (slot >= ADDR_W'(IDX_REQ_BASE) &&
                     slot <  ADDR_W'(IDX_REQ_BASE + NUM_CPU)) begin
            kind    = KIND_REQ;
            cpu_sel = CPU_W'(req_off);
        end else if (slot == ADDR_W'(IDX_RAW)) begin
            kind = KIND_RAW;
        end
        // timing, address array, probe, count, message and all other
        // slots stay KIND_BAD
    end

endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
    import irq_regblk_pkg::*;
#(
    parameter int  NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  reg_kind_e         acc_kind,
    input  logic [CPU_W-1:0]  acc_cpu,
    input  logic              acc_size_ok,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              rtc_pulse,
    output logic              acc_err,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              rtc_flag
);

    typedef struct packed {
        logic [NUM_CPU-1:0][DATA_W-1:0] mask;
        logic [NUM_CPU-1:0][DATA_W-1:0] req;
        logic [DATA_W-1:0]              raw;
        logic                           rtc;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              commit;
    logic [NUM_CPU-1:0] mask_we;
    logic              rtc_ack;
    logic [DATA_W-1:0] misc_view;

    assign misc_view = DATA_W'(regs_q.rtc) << RTC_BIT;

    // access legality
    always_comb begin
        acc_err = 1'b0;
        if (!acc_size_ok) begin
            acc_err = 1'b1;
        end else begin
            unique case (acc_kind)
                KIND_CTRL: acc_err = acc_write;
                KIND_MISC: acc_err = acc_write && !acc_wdata[RTC_BIT];
                KIND_MASK: acc_err = 1'b0;
                KIND_REQ:  acc_err = acc_write;
                KIND_RAW:  acc_err = acc_write;
                default:   acc_err = 1'b1;
            endcase
        end
        commit  = acc_valid && acc_write && !acc_err;
        rtc_ack = commit && (acc_kind == KIND_MISC);
    end

    // one write enable per processor mask
    for (genvar n = 0; n < NUM_CPU; n++) begin : g_mask_we
        assign mask_we[n] = commit && (acc_kind == KIND_MASK) &&
                            (acc_cpu == CPU_W'(n));
    end

    // read path
    always_comb begin
        acc_rdata = '0;
        if (acc_valid && !acc_write && !acc_err) begin
            unique case (acc_kind)
                KIND_CTRL: acc_rdata = '0;
                KIND_MISC: acc_rdata = misc_view;
                KIND_MASK: acc_rdata = regs_q.mask[acc_cpu];
                KIND_REQ:  acc_rdata = regs_q.req[acc_cpu];
                KIND_RAW:  acc_rdata = regs_q.raw;
                default:   acc_rdata = '0;
            endcase
        end
    end

    // next state
    always_comb begin
        regs_d = regs_q;
        for (int n = 0; n < NUM_CPU; n++) begin
            if (mask_we[n]) begin
                regs_d.mask[n] = acc_wdata;
            end
        end
        // a new RTC event outranks a same-cycle acknowledge
        if (rtc_pulse) begin
            regs_d.rtc = 1'b1;
        end else if (rtc_ack) begin
            regs_d.rtc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rtc_flag = regs_q.rtc;

endmodule

// File: rtl/irq_regblk.sv
module irq_regblk
    import irq_regblk_pkg::*;
#(
    parameter int                ADDR_W    = 36,
    parameter logic [ADDR_W-1:0] ADDR_MASK = 36'h0_0000_07C0,
    parameter int                NUM_CPU   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    input  logic              rtc_pulse,
    output logic              rsp_ready,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic              rtc_irq
);

    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    typedef struct packed {
        logic              ready;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    reg_kind_e         kind;
    logic [CPU_W-1:0]  cpu_sel;
    logic              size_ok;
    logic              acc_err;
    logic [DATA_W-1:0] acc_rdata;
    logic              rtc_flag;

    irq_addr_decode #(
        .ADDR_W    (ADDR_W),
        .ADDR_MASK (ADDR_MASK),
        .NUM_CPU   (NUM_CPU)
    ) u_decode (
        .addr    (req_addr),
        .size    (req_size),
        .kind    (kind),
        .cpu_sel (cpu_sel),
        .size_ok (size_ok)
    );

    irq_reg_file #(
        .NUM_CPU (NUM_CPU)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (req_valid),
        .acc_write   (req_write),
        .acc_kind    (kind),
        .acc_cpu     (cpu_sel),
        .acc_size_ok (size_ok),
        .acc_wdata   (req_wdata),
        .rtc_pulse   (rtc_pulse),
        .acc_err     (acc_err),
        .acc_rdata   (acc_rdata),
        .rtc_flag    (rtc_flag)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.ready = req_valid;
        if (req_valid) begin
            rsp_d.err   = acc_err;
            rsp_d.rdata = acc_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_ready = rsp_q.ready;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;
    assign rtc_irq   = rtc_flag;

endmodule

// File: rtl/irq_regblk_chk.sv
module irq_regblk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic [63:0] req_wdata,
    input logic        rtc_pulse,
    input logic        rsp_ready,
    input logic        rsp_err,
    input logic [63:0] rsp_rdata,
    input logic        rtc_irq
);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ready);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ready);

    // R3
    narrow_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 2'd3) |=> rsp_err);

    // R9
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && rsp_err) |-> (rsp_rdata == 64'd0));

    // R7
    rtc_pulse_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_pulse |=> rtc_irq);

    // R7
    rtc_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rtc_irq) |-> $past(rtc_pulse));

    // R8
    rtc_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rtc_irq) |-> $past(req_valid && req_write && req_size == 2'd3 &&
                                 req_wdata[7] && !rtc_pulse));

endmodule

bind irq_regblk irq_regblk_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rtc_pulse (rtc_pulse),
    .rsp_ready (rsp_ready),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .rtc_irq   (rtc_irq)
);

// File: tb/irq_regblk_tb.sv
module irq_regblk_tb_top;

    localparam int AW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'd3;
    logic [63:0]   req_wdata = '0;
    logic          rtc_pulse = 1'b0;
    logic          rsp_ready;
    logic          rsp_err;
    logic [63:0]   rsp_rdata;
    logic          rtc_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_regblk dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rtc_pulse (rtc_pulse),
        .rsp_ready (rsp_ready),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .rtc_irq   (rtc_irq)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] slot(int idx);
        return AW'(idx) << 6;
    endfunction

    // one access; returns response sampled at the negedge after the capture edge
    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic [63:0] wd, input bit pulse,
                          output logic err, output logic [63:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
        req_wdata = wd; rtc_pulse = pulse;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; rtc_pulse = 1'b0;
        check("R2 ready", 64'(rsp_ready), 64'd1);
        err = rsp_err;
        rd  = rsp_rdata;
    endtask

    task automatic rd_expect(string tag, int idx, logic [63:0] exp);
        logic e; logic [63:0] d;
        access(1'b0, slot(idx), 2'd3, '0, 1'b0, e, d);
        check({tag, " rd err"}, 64'(e), 64'd0);
        check({tag, " rd data"}, d, exp);
    endtask

    task automatic wr_expect_err(string tag, int idx, logic [63:0] wd, logic [1:0] sz, bit exp_err);
        logic e; logic [63:0] d;
        access(1'b1, slot(idx), sz, wd, 1'b0, e, d);
        check({tag, " wr err"}, 64'(e), 64'(exp_err));
    endtask

    task automatic t_reset();
        check("R1 ready idle", 64'(rsp_ready), 64'd0);
        check("R1 irq idle", 64'(rtc_irq), 64'd0);
        for (int n = 0; n < 4; n++) rd_expect("R1 mask", 8 + n, 64'd0);
        rd_expect("R1 misc", 2, 64'd0);
        @(negedge clk);
        check("R2 ready drops", 64'(rsp_ready), 64'd0);
    endtask

    task automatic t_mask();
        for (int n = 0; n < 4; n++)
            wr_expect_err("R4 mask", 8 + n, 64'hA5A5_0000_0000_0000 + 64'(n * 17 + 1), 2'd3, 1'b0);
        for (int n = 0; n < 4; n++)
            rd_expect("R4 mask", 8 + n, 64'hA5A5_0000_0000_0000 + 64'(n * 17 + 1));
        wr_expect_err("R4 mask1 rewrite", 9, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0);
        rd_expect("R4 mask1", 9, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_expect("R4 mask0 intact", 8, 64'hA5A5_0000_0000_0001);
        rd_expect("R4 mask2 intact", 10, 64'hA5A5_0000_0000_0023);
    endtask

    task automatic t_size();
        logic e; logic [63:0] d;
        for (int s = 0; s < 3; s++) begin
            access(1'b1, slot(8), 2'(s), 64'h1234, 1'b0, e, d);
            check("R3 narrow wr err", 64'(e), 64'd1);
            access(1'b0, slot(8), 2'(s), '0, 1'b0, e, d);
            check("R3 narrow rd err", 64'(e), 64'd1);
            check("R3 narrow rd data", d, 64'd0);
        end
        rd_expect("R3 mask0 unchanged", 8, 64'hA5A5_0000_0000_0001);
    endtask

    task automatic t_readonly();
        for (int n = 0; n < 4; n++) begin
            rd_expect("R5 req", 12 + n, 64'd0);
            wr_expect_err("R5 req", 12 + n, 64'hDEAD, 2'd3, 1'b1);
            rd_expect("R5 req after wr", 12 + n, 64'd0);
        end
        rd_expect("R5 raw", 16, 64'd0);
        wr_expect_err("R5 raw", 16, 64'hBEEF, 2'd3, 1'b1);
        rd_expect("R5 raw after wr", 16, 64'd0);
    endtask

    task automatic t_ctrl();
        rd_expect("R6 ctrl", 0, 64'd0);
        wr_expect_err("R6 ctrl", 0, 64'hFFFF, 2'd3, 1'b1);
        rd_expect("R6 ctrl after wr", 0, 64'd0);
    endtask

    task automatic t_rtc();
        @(negedge clk); rtc_pulse = 1'b1;
        @(negedge clk); rtc_pulse = 1'b0;
        check("R7 irq raised", 64'(rtc_irq), 64'd1);
        repeat (5) @(negedge clk);
        check("R7 irq held", 64'(rtc_irq), 64'd1);
        rd_expect("R7 misc bit7", 2, 64'h80);
        wr_expect_err("R8 bit7 clear wr", 2, 64'h7F, 2'd3, 1'b1);
        check("R8 irq kept after bad wr", 64'(rtc_irq), 64'd1);
        rd_expect("R8 misc kept", 2, 64'h80);
        wr_expect_err("R8 ack", 2, 64'h80, 2'd3, 1'b0);
        check("R8 irq cleared", 64'(rtc_irq), 64'd0);
        rd_expect("R8 misc cleared", 2, 64'd0);
    endtask

    task automatic t_collide();
        logic e; logic [63:0] d;
        access(1'b1, slot(2), 2'd3, 64'h80, 1'b1, e, d);
        check("R11 ack err", 64'(e), 64'd0);
        check("R11 pulse wins", 64'(rtc_irq), 64'd1);
        wr_expect_err("R11 ack", 2, 64'h80, 2'd3, 1'b0);
        check("R11 irq clear", 64'(rtc_irq), 64'd0);
    endtask

    task automatic t_unsupported();
        int bad[14] = '{1, 3, 4, 7, 17, 18, 20, 23, 24, 27, 28, 31, 5, 26};
        logic e; logic [63:0] d;
        foreach (bad[k]) begin
            access(1'b0, slot(bad[k]), 2'd3, '0, 1'b0, e, d);
            check("R9 rd err", 64'(e), 64'd1);
            check("R9 rd data", d, 64'd0);
            access(1'b1, slot(bad[k]), 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, e, d);
            check("R9 wr err", 64'(e), 64'd1);
        end
        rd_expect("R9 mask3 unchanged", 11, 64'hA5A5_0000_0000_0034);
        check("R9 irq unchanged", 64'(rtc_irq), 64'd0);
    endtask

    task automatic t_decode();
        logic e; logic [63:0] d;
        logic [AW-1:0] a;
        a = slot(9) | AW'('h3F) | (AW'(1) << 20) | (AW'(1) << 35);
        access(1'b1, a, 2'd3, 64'h0123_4567_89AB_CDEF, 1'b0, e, d);
        check("R10 stray-bit wr err", 64'(e), 64'd0);
        rd_expect("R10 mask1 reached", 9, 64'h0123_4567_89AB_CDEF);
        a = slot(8) | AW'('h15) | (AW'(1) << 12);
        access(1'b0, a, 2'd3, '0, 1'b0, e, d);
        check("R10 stray-bit rd err", 64'(e), 64'd0);
        check("R10 stray-bit rd data", d, 64'hA5A5_0000_0000_0001);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_size();
        t_readonly();
        t_ctrl();
        t_rtc();
        t_collide();
        t_unsupported();
        t_decode();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule